// File: doc/BRIEF.md
# SPI Slave Register Access Engine

This block lets an external SPI host read and write a 128-entry byte register file. The host lowers chip select and sends a command byte. Its first bit gives the direction, where 1 means read and 0 means write, and its remaining seven bits give the register address, most significant bit first. After the command byte a write carries data bytes. A read returns data bytes on MISO while the host keeps sending bytes on MOSI. When auto-increment is off those bytes name the next register to read. When it is on they are ignored, except for an all-zero byte, which ends the read. Any byte cut short by chip select rising is dropped.

SCLK, chip select and MOSI are brought into the system clock domain through a synchronizer and an edge detector. The system clock must run at least eight times faster than SCLK. All four clock polarity and phase combinations are supported. The polarity, phase and auto-increment settings come from pins driven by a configuration register outside this block. The engine captures them on the falling edge of chip select, so a change made during a transfer applies only from the next transfer.

The register file sits outside the block. Reads are combinational: `rd_data` must reflect `rd_addr` in the same cycle. Writes use a valid-only stream: `wr_valid` pulses for one cycle with `wr_addr` and `wr_data`. There is no ready signal, so the register file must accept a write in any cycle.

Top module: `spi_reg_engine`

## Requirements
- R1: After reset, `miso` and `wr_valid` are 0, `rd_addr` is 0, and the captured mode is polarity 0, phase 0, with auto-increment off.
- R2: The first bit received after chip select falls selects the direction (1 = read, 0 = write). The next 7 bits are the register address, MSB first.
- R3: During a read, MISO carries 0 while the command byte is being received. The byte after the command byte carries the contents of the addressed register, MSB first, starting at the first launch edge after the last address bit.
- R4: During a read with auto-increment off, each MOSI byte received after the command byte is the address whose contents appear on MISO in the following byte. Only its low 7 bits are used.
- R5: During a read with auto-increment on, non-zero MOSI bytes are ignored and each further MISO byte comes from the previous address plus one. The address wraps from 0x7F to 0x00.
- R6: During a read, an all-zero MOSI byte ends the read. The byte that is shifting out alongside it still completes. After that, MISO stays 0 until chip select rises.
- R7: During a write, each data byte produces exactly one single-cycle `wr_valid` pulse, and only after all 8 of its bits have arrived. With auto-increment off, every data byte goes to the command's address. With auto-increment on, the address rises by one per byte and wraps from 0x7F to 0x00.
- R8: If chip select rises before the last bit of a byte has been received, that byte is discarded and produces no write.
- R9: Polarity sets the idle level of SCLK. With phase 0, bits are sampled on the leading edge; with phase 1, on the trailing edge. All four combinations transfer data correctly.
- R10: Polarity, phase and auto-increment are captured when chip select falls. Changes to `cfg_*` while chip select is low do not affect the current transfer.
- R11: While chip select is high, `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cfg_cpol | input | 1 | Requested clock polarity for the next transfer |
| cfg_cpha | input | 1 | Requested clock phase for the next transfer |
| cfg_auto_inc | input | 1 | Requested auto-increment for the next transfer |
| rd_addr | output | 7 | Register file read address |
| rd_data | input | 8 | Register file read data, valid in the same cycle as `rd_addr` |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | 7 | Write address, qualified by `wr_valid` |
| wr_data | output | 8 | Write data, qualified by `wr_valid` |

## Verification
The assertions rely on three assumptions about the inputs:
- SCLK half periods last at least four system clocks.
- MOSI is stable around each sampling edge, measured after the synchronizer delay.
- Chip select stays low for several system clocks after the final SCLK edge, and stays high long enough between transfers for the synchronized level to settle.

The stimulus meets these assumptions by using a 16-cycle SCLK period, a half period of idle time before the first and after the last edge, and gaps of at least two half periods with chip select high. Configuration pins change either between transfers or in the middle of a transfer on purpose. Chip select rises mid-byte only in the abort cases.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Phase of the current chip-select frame
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_HALT  = 2'd3
  } phase_e;

  // Settings captured at the start of a frame
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic auto_inc;
  } link_cfg_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= g_stage[s-1].q;
      end
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/spi_edge_pick.sv
module spi_edge_pick #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic pol,   // 0: leading edge is rising, 1: leading edge is falling
  output logic lead,
  output logic trail
);

  logic prev;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RESET_VAL;
    else        prev <= level;
  end

  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
  assign lead  = pol ? fall : rise;
  assign trail = pol ? rise : fall;

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sample,
  input  logic              launch,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              miso,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      miso      <= 1'b0;
      byte_done <= 1'b0;
    end else if (!active) begin
      // frame closed or aborted: a partial byte is simply dropped
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      miso      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sample) begin
        rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
      end
      if (launch) begin
        miso  <= tx_sh[BYTE_W-1];
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
      if (load) tx_sh <= load_byte;
    end
  end

  assign rx_byte = rx_sh;

  AST_ONE_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done); // R2

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && $past(!active)) |-> !miso); // R11

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_auto_inc,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W:0]   rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W:0]   wr_data
);

  localparam int BYTE_W = ADDR_W + 1;
  // lanes: [2] chip select (idle high), [1] sclk, [0] mosi
  localparam logic [2:0] LANE_RST = 3'b100;

  logic [2:0]        lane_lvl;
  logic              frame_start, frame_end;
  logic              sck_lead, sck_trail;
  logic              active, sample, launch;
  link_cfg_t         link;
  phase_e            phase;
  logic [ADDR_W-1:0] cur_addr;
  logic              load_req;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(LANE_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, sclk, mosi}),
    .dout (lane_lvl)
  );

  spi_edge_pick #(.RESET_VAL(1'b1)) u_cs_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .level(lane_lvl[2]),
    .pol  (1'b1),
    .lead (frame_start),
    .trail(frame_end)
  );

  spi_edge_pick #(.RESET_VAL(1'b0)) u_sck_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .level(lane_lvl[1]),
    .pol  (link.cpol),
    .lead (sck_lead),
    .trail(sck_trail)
  );

  assign active = ~lane_lvl[2];
  assign sample = active & (link.cpha ? sck_trail : sck_lead);
  assign launch = active & (link.cpha ? sck_lead  : sck_trail);

  // mode and auto-increment are frozen for the whole frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           link <= '0;
    else if (frame_start) link <= '{cpol: cfg_cpol, cpha: cfg_cpha, auto_inc: cfg_auto_inc};
  end

  spi_bit_engine #(.BYTE_W(BYTE_W)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .sample   (sample),
    .launch   (launch),
    .mosi_s   (lane_lvl[0]),
    .load     (load_req),
    .load_byte(rd_data),
    .miso     (miso),
    .byte_done(byte_done),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      cur_addr <= '0;
      load_req <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (frame_end) begin
      phase    <= PH_CMD;
      load_req <= 1'b0;
      wr_valid <= 1'b0;
    end else begin
      load_req <= 1'b0;
      wr_valid <= 1'b0;
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            cur_addr <= rx_byte[ADDR_W-1:0];
            if (rx_byte[BYTE_W-1]) begin
              phase    <= PH_READ;
              load_req <= 1'b1;
            end else begin
              phase <= PH_WRITE;
            end
          end
          PH_WRITE: begin
            wr_valid <= 1'b1;
            wr_addr  <= cur_addr;
            wr_data  <= rx_byte;
            if (link.auto_inc) cur_addr <= cur_addr + 1'b1;
          end
          PH_READ: begin
            if (rx_byte == '0) begin
              phase <= PH_HALT;
            end else begin
              cur_addr <= link.auto_inc ? cur_addr + 1'b1 : rx_byte[ADDR_W-1:0];
              load_req <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = cur_addr;

  // write history within a frame, kept only for the checks below
  logic [ADDR_W-1:0] prev_wr_addr;
  logic              wr_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wr_addr <= '0;
      wr_seen      <= 1'b0;
    end else if (frame_end) begin
      wr_seen <= 1'b0;
    end else if (wr_valid) begin
      prev_wr_addr <= wr_addr;
      wr_seen      <= 1'b1;
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R7

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_seen && link.auto_inc) |-> (wr_addr == ADDR_W'(prev_wr_addr + 1'b1))); // R7

  AST_WR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_seen && !link.auto_inc) |-> (wr_addr == prev_wr_addr)); // R7

  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(active, 2)) |-> $stable(link)); // R10

  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> active); // R8

endmodule

// File: tb/tb_spi_reg_engine.sv
module tb_spi_reg_engine;

  localparam int H = 8; // sclk half period in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_auto_inc = 1'b0;
  logic       miso, wr_valid;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  always #5 clk = ~clk;

  spi_reg_engine dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_auto_inc(cfg_auto_inc),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // bench-side register file and its model shadow
  logic [7:0] regs [128];
  logic [7:0] mdl  [128];
  assign rd_data = regs[rd_addr];
  always @(posedge clk) if (wr_valid) regs[wr_addr] <= wr_data;

  int n_chk = 0, n_fail = 0;
  int exp_wa[$], exp_wd[$];
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  logic m_cpol = 1'b0, m_cpha = 1'b0;
  int cs_high_cnt = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of write strobes and idle MISO
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_wa.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R8 unexpected write actual=%0h expected=none", wr_addr);
        end else begin
          chk("R7 write address", wr_addr, exp_wa.pop_front());
          chk("R7 write data", wr_data, exp_wd.pop_front());
        end
      end
      cs_high_cnt = cs_n ? cs_high_cnt + 1 : 0;
      if (cs_high_cnt > 6) chk("R11 miso idle", miso, 0);
    end
  end

  task automatic spi_xfer(input int n, input int cut);
    sclk = m_cpol;
    repeat (2*H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      for (int j = 7; j >= 0; j--) begin
        if (i == n-1 && cut >= 0 && (7-j) == cut) begin
          cs_n = 1'b1;
          repeat (4*H) @(negedge clk);
          return;
        end
        if (!m_cpha) begin
          mosi = txb[i][j];
          repeat (H) @(negedge clk);
          rxb[i][j] = miso;
          sclk = ~m_cpol;
          repeat (H) @(negedge clk);
          sclk = m_cpol;
        end else begin
          sclk = ~m_cpol;
          mosi = txb[i][j];
          repeat (H) @(negedge clk);
          rxb[i][j] = miso;
          sclk = m_cpol;
          repeat (H) @(negedge clk);
        end
      end
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  // write burst: data already in txb[1..nd]
  task automatic wr_burst(input int addr, input int nd, input bit auto_on);
    int a = addr;
    txb[0] = {1'b0, 7'(addr)};
    for (int k = 1; k <= nd; k++) begin
      exp_wa.push_back(a);
      exp_wd.push_back(txb[k]);
      mdl[a] = txb[k];
      if (auto_on) a = (a + 1) % 128;
    end
    spi_xfer(nd + 1, -1);
    chk("R7 all writes delivered", exp_wa.size(), 0);
  endtask

  // read burst: follow-up MOSI bytes already in txb[1..nb]
  task automatic rd_burst(input int addr, input int nb, input bit auto_on, input string tag);
    int a = addr;
    bit ended = 0;
    txb[0] = {1'b1, 7'(addr)};
    spi_xfer(nb + 1, -1);
    chk("R3 miso zero during command", rxb[0], 0);
    for (int k = 1; k <= nb; k++) begin
      chk(tag, rxb[k], ended ? 0 : int'(mdl[a]));
      if (!ended) begin
        if (txb[k] == 8'h00) ended = 1;
        else a = auto_on ? (a + 1) % 128 : int'(txb[k][6:0]);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      regs[i] = 8'(i*37 + 11);
      mdl[i]  = 8'(i*37 + 11);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset miso", miso, 0);
    chk("R1 reset wr_valid", wr_valid, 0);
    chk("R1 reset rd_addr", rd_addr, 0);

    // R2 R7: single write in mode 0, then R3 R6 read back
    txb[1] = 8'hA5;
    wr_burst(7'h05, 1, 0);
    txb[1] = 8'h00; txb[2] = 8'h3C;
    rd_burst(7'h05, 2, 0, "R3 R6 read then stop");

    // R7 auto-increment write wrapping past 0x7F
    cfg_auto_inc = 1'b1;
    txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
    wr_burst(7'h7E, 3, 1);

    // R7 fixed-address write
    cfg_auto_inc = 1'b0;
    txb[1] = 8'h44; txb[2] = 8'h55;
    wr_burst(7'h10, 2, 0);

    // R4 full-duplex read, R6 zero byte ends it
    txb[1] = 8'h10; txb[2] = 8'h7F; txb[3] = 8'h00; txb[4] = 8'hAA;
    rd_burst(7'h7E, 4, 0, "R4 R6 full duplex read");

    // R5 auto-increment read ignores MOSI and wraps
    cfg_auto_inc = 1'b1;
    txb[1] = 8'h33; txb[2] = 8'h44; txb[3] = 8'h55;
    rd_burst(7'h7E, 3, 1, "R5 auto-increment read");
    cfg_auto_inc = 1'b0;

    // R9 other three modes
    for (int m = 1; m < 4; m++) begin
      m_cpol = m[1]; m_cpha = m[0];
      cfg_cpol = m[1]; cfg_cpha = m[0];
      txb[1] = 8'(8'h5A ^ m);
      wr_burst(7'h40 + m, 1, 0);
      txb[1] = 8'h00;
      rd_burst(7'h40 + m, 1, 0, "R9 mode read back");
    end

    // R8 abort mid data byte and mid command byte (mode 0)
    m_cpol = 0; m_cpha = 0; cfg_cpol = 0; cfg_cpha = 0;
    txb[0] = {1'b0, 7'h30}; txb[1] = 8'h99; txb[2] = 8'h66;
    exp_wa.push_back(7'h30); exp_wd.push_back(8'h99); mdl[7'h30] = 8'h99;
    spi_xfer(3, 5);
    chk("R8 only complete byte written", exp_wa.size(), 0);
    txb[0] = {1'b0, 7'h31};
    spi_xfer(1, 3);
    txb[1] = 8'h31; txb[2] = 8'h00;
    rd_burst(7'h30, 2, 0, "R8 registers untouched by aborted bytes");

    // R10 configuration changed mid-transfer applies only next frame
    txb[1] = 8'h01; txb[2] = 8'h02; txb[3] = 8'h03;
    fork
      wr_burst(7'h50, 3, 0);
      begin
        repeat (60) @(negedge clk);
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_auto_inc = 1'b1;
      end
    join
    m_cpol = 1; m_cpha = 1;
    txb[1] = 8'h77; txb[2] = 8'h00; txb[3] = 8'h12;
    rd_burst(7'h50, 3, 1, "R10 new mode in next frame");

    repeat (20) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule